// File: doc/BRIEF.md
# Dual Input Tape Reader

This block answers the read instruction of a small processor against two sequential input streams. Tape 0 holds the primary input and tape 1 the auxiliary input. Each tape is a word buffer with its own length count, filled before execution through a write port that appends one word per cycle to the tape named by the write index. A read request carries a W-bit selector. The block returns the next unread word of the chosen tape and moves that tape's read pointer forward. If the tape has nothing left, it returns zero and raises the flag.

Selector values other than 0 and 1 address a tape that is always empty. Once a read finds a tape empty, that tape stays empty until reset, even if more words are appended afterwards. A synchronous reset rewinds both read pointers and clears exhaustion. It keeps the loaded words and lengths, so the same program input can be replayed.

A two-state machine sequences the reply. In `ST_IDLE` no reply is pending. A request in either state moves to `ST_REPLY` (transition *request*), where `rd_valid` is high for that cycle. A cycle without a request returns to `ST_IDLE` (transition *quiet*). Reset forces `ST_IDLE`.

Top module: `dual_tape_reader`

## Requirements
- R1: Selector value 0 reads tape 0 and selector value 1 reads tape 1. Each tape returns its words in the order they were written.
- R2: When the selected tape still holds an unread word, that word is returned with flag 0, and the tape's read pointer advances by one.
- R3: When the selected tape has no unread word, the result is all zeros and the flag is 1.
- R4: Any selector value other than 0 or 1 returns all zeros with flag 1, and neither tape's pointer moves.
- R5: Whenever a valid reply carries flag 1, its word is zero.
- R6: Once a read finds a tape empty, every later read of that tape returns zero with flag 1 until reset, including after further words are written to it.
- R7: `rd_valid` is 1 in exactly the cycle after each cycle with `rd_req` high, and 0 otherwise. The reply word and flag appear in that same cycle.
- R8: A read of one tape never changes the other tape's read pointer.
- R9: A synchronous reset sets `rd_word`, `rd_flag` and `rd_valid` to 0, rewinds both read pointers to 0 and clears exhaustion. It keeps the stored words and lengths.
- R10: Each tape holds at most DEPTH words. A write to a full tape is ignored.
- R11: A write with `wr_en` high appends `wr_data` to tape `wr_tape` (0 = primary, 1 = auxiliary) after its last word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Append one word to a tape |
| wr_tape | input | 1 | Tape receiving the write: 0 primary, 1 auxiliary |
| wr_data | input | W | Word to append |
| rd_req | input | 1 | Read request |
| rd_sel | input | W | Tape selector of the read |
| rd_word | output | W | Word returned by the last read |
| rd_flag | output | 1 | 1 when the last read found no word |
| rd_valid | output | 1 | Reply present this cycle |

## Verification
The bench builds the block with W = 16 and DEPTH = 4. The small depth lets a handful of writes fill tape 0 and then try a fifth word that must be dropped. Tape 1 receives only two words, so its exhaustion is reached early, while tape 0 still has words left. This interleaves empty and non-empty replies, valid and out-of-range selectors, and a post-exhaustion append. A reset then shows the kept lengths being replayed.

// File: rtl/tape_pkg.sv
package tape_pkg;
    localparam int NUM_TAPES = 2;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_REPLY = 1'b1
    } rd_state_e;
endpackage

// File: rtl/tape_sel_decode.sv
module tape_sel_decode #(
    parameter int W = 16
) (
    input  logic [W-1:0]                    sel,
    output logic [tape_pkg::NUM_TAPES-1:0] hit
);
    always_comb begin
        for (int t = 0; t < tape_pkg::NUM_TAPES; t++) begin
            hit[t] = (sel == W'(t));
        end
    end
endmodule

// File: rtl/tape_lane.sv
module tape_lane #(
    parameter int W     = 16,
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int PW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    input  logic          pop,
    output logic [W-1:0]  head_word,
    output logic          avail,
    output logic          exhausted,
    output logic [PW-1:0] ptr
);
    logic [W-1:0]  mem_q [DEPTH];
    logic [PW-1:0] len_q = '0;
    logic [PW-1:0] ptr_q;
    logic          exh_q;

    // Append port: contents and length survive reset.
    always_ff @(posedge clk) begin
        if (wr_en && (len_q < PW'(DEPTH))) begin
            mem_q[len_q[AW-1:0]] <= wr_data;
            len_q                <= len_q + PW'(1);
        end
    end

    assign avail     = !exh_q && (ptr_q < len_q);
    assign head_word = mem_q[ptr_q[AW-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
            exh_q <= 1'b0;
        end else if (pop) begin
            if (avail) begin
                ptr_q <= ptr_q + PW'(1);
            end else begin
                exh_q <= 1'b1;
            end
        end
    end

    assign exhausted = exh_q;
    assign ptr       = ptr_q;
endmodule

// File: rtl/dual_tape_reader.sv
module dual_tape_reader #(
    parameter int W     = 16,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic         wr_tape,
    input  logic [W-1:0] wr_data,
    input  logic         rd_req,
    input  logic [W-1:0] rd_sel,
    output logic [W-1:0] rd_word,
    output logic         rd_flag,
    output logic         rd_valid
);
    import tape_pkg::*;

    localparam int PW = $clog2(DEPTH + 1);

    logic [NUM_TAPES-1:0]         sel_hit;
    logic [NUM_TAPES-1:0]         lane_avail;
    logic [NUM_TAPES-1:0]         lane_exh;
    logic [NUM_TAPES-1:0][W-1:0]  lane_word;
    logic [NUM_TAPES-1:0][PW-1:0] lane_ptr;

    rd_state_e state_q, state_d;
    logic [W-1:0] word_d;
    logic         flag_d;

    tape_sel_decode #(.W(W)) u_dec (
        .sel (rd_sel),
        .hit (sel_hit)
    );

    for (genvar t = 0; t < NUM_TAPES; t++) begin : g_lane
        tape_lane #(.W(W), .DEPTH(DEPTH)) u_lane (
            .clk       (clk),
            .rst       (rst),
            .wr_en     (wr_en && (wr_tape == 1'(t))),
            .wr_data   (wr_data),
            .pop       (rd_req && sel_hit[t]),
            .head_word (lane_word[t]),
            .avail     (lane_avail[t]),
            .exhausted (lane_exh[t]),
            .ptr       (lane_ptr[t])
        );
    end

    // Next state.
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE:  state_d = rd_req ? ST_REPLY : ST_IDLE;
            ST_REPLY: state_d = rd_req ? ST_REPLY : ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Reply selection: an unmatched or empty tape yields zero with flag set.
    always_comb begin
        word_d = '0;
        flag_d = 1'b1;
        for (int t = 0; t < NUM_TAPES; t++) begin
            if (sel_hit[t] && lane_avail[t]) begin
                word_d = lane_word[t];
                flag_d = 1'b0;
            end
        end
    end

    // Output process.
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_word <= '0;
            rd_flag <= 1'b0;
        end else if (rd_req) begin
            rd_word <= word_d;
            rd_flag <= flag_d;
        end
    end

    assign rd_valid = (state_q == ST_REPLY);
endmodule

// File: rtl/tape_reader_chk.sv
module tape_reader_chk #(
    parameter int W  = 16,
    parameter int PW = 5
) (
    input logic               clk,
    input logic               rst,
    input logic               rd_req,
    input logic [W-1:0]       rd_sel,
    input logic [W-1:0]       rd_word,
    input logic               rd_flag,
    input logic               rd_valid,
    input logic [1:0]         lane_exh,
    input logic [1:0][PW-1:0] lane_ptr
);
    p_zero_word_on_flag_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_flag) |-> (rd_word == '0));

    p_bad_sel_empty_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_req && (rd_sel > W'(1))) |=> (rd_valid && rd_flag));

    p_valid_after_req_r7: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> rd_valid);

    p_no_stray_valid_r7: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> !rd_valid);

    p_sticky_tape0_r6: assert property (@(posedge clk) disable iff (rst)
        lane_exh[0] |=> lane_exh[0]);

    p_sticky_tape1_r6: assert property (@(posedge clk) disable iff (rst)
        lane_exh[1] |=> lane_exh[1]);

    p_other_ptr0_still_r8: assert property (@(posedge clk) disable iff (rst)
        !(rd_req && (rd_sel == '0)) |=> $stable(lane_ptr[0]));

    p_other_ptr1_still_r8: assert property (@(posedge clk) disable iff (rst)
        !(rd_req && (rd_sel == W'(1))) |=> $stable(lane_ptr[1]));

    p_rewind_r9: assert property (@(posedge clk)
        rst |=> (lane_ptr[0] == '0 && lane_ptr[1] == '0 && lane_exh == 2'b00 && !rd_valid));
endmodule

bind dual_tape_reader tape_reader_chk #(.W(W), .PW(PW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .rd_req   (rd_req),
    .rd_sel   (rd_sel),
    .rd_word  (rd_word),
    .rd_flag  (rd_flag),
    .rd_valid (rd_valid),
    .lane_exh (lane_exh),
    .lane_ptr (lane_ptr)
);

// File: tb/tb_dual_tape_reader.sv
module tb_dual_tape_reader;
    localparam int W     = 16;
    localparam int DEPTH = 4;
    localparam int NV    = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic         wr_tape = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         rd_req = 1'b0;
    logic [W-1:0] rd_sel = '0;
    logic [W-1:0] rd_word;
    logic         rd_flag;
    logic         rd_valid;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    dual_tape_reader #(.W(W), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_tape(wr_tape), .wr_data(wr_data),
        .rd_req(rd_req), .rd_sel(rd_sel), .rd_word(rd_word), .rd_flag(rd_flag),
        .rd_valid(rd_valid)
    );

    // Read vectors after loading tape0 = 1100..1103 (+ dropped DEAD), tape1 = 2200, 2201.
    localparam logic [W-1:0] V_SEL  [NV] = '{16'h0000, 16'h0001, 16'h0002, 16'h0000, 16'hFFFF,
                                             16'h0001, 16'h0001, 16'h0000, 16'h0000, 16'h0000};
    localparam logic [W-1:0] V_WORD [NV] = '{16'h1100, 16'h2200, 16'h0000, 16'h1101, 16'h0000,
                                             16'h2201, 16'h0000, 16'h1102, 16'h1103, 16'h0000};
    localparam bit           V_FLAG [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1,
                                             1'b0, 1'b1, 1'b0, 1'b0, 1'b1};

    task automatic check(input string req, input logic [W-1:0] got_w, input logic got_f,
                         input logic got_v, input logic [W-1:0] exp_w, input logic exp_f,
                         input logic exp_v);
        checks++;
        if (got_w !== exp_w || got_f !== exp_f || got_v !== exp_v) begin
            errors++;
            $display("FAIL %s: word=%h flag=%b valid=%b expected word=%h flag=%b valid=%b",
                     req, got_w, got_f, got_v, exp_w, exp_f, exp_v);
        end
    endtask

    task automatic put(input logic tape, input logic [W-1:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_tape = tape; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_chk(input string req, input logic [W-1:0] sel,
                            input logic [W-1:0] exp_w, input logic exp_f);
        @(negedge clk);
        rd_req = 1'b1; rd_sel = sel;
        @(negedge clk);
        rd_req = 1'b0;
        check(req, rd_word, rd_flag, rd_valid, exp_w, exp_f, 1'b1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R9 reset outputs", rd_word, rd_flag, rd_valid, '0, 1'b0, 1'b0);

        // R11: appends by tape index; R10: fifth word on tape 0 dropped.
        for (int i = 0; i < DEPTH; i++) put(1'b0, 16'h1100 + 16'(i));
        put(1'b0, 16'hDEAD);
        put(1'b1, 16'h2200);
        put(1'b1, 16'h2201);

        // R1 R2 R3 R4 R5 R8 R10: vector walk.
        for (int v = 0; v < NV; v++) begin
            read_chk($sformatf("R1/R2/R3/R4/R5/R8/R10 vector %0d", v), V_SEL[v], V_WORD[v], V_FLAG[v]);
        end

        // R7: no request, no valid.
        @(negedge clk);
        check("R7 idle no valid", rd_word, rd_flag, rd_valid, '0, 1'b1, 1'b0);

        // R6: append to exhausted tape 1 keeps it empty.
        put(1'b1, 16'h2202);
        read_chk("R6 sticky after append", 16'h0001, '0, 1'b1);
        read_chk("R6 tape0 stays empty", 16'h0000, '0, 1'b1);

        // R9: reset rewinds, keeps contents and lengths.
        do_reset();
        check("R9 outputs after reset", rd_word, rd_flag, rd_valid, '0, 1'b0, 1'b0);
        read_chk("R9 replay tape0", 16'h0000, 16'h1100, 1'b0);
        read_chk("R9 replay tape1 first", 16'h0001, 16'h2200, 1'b0);
        read_chk("R8 tape0 unaffected", 16'h0000, 16'h1101, 1'b0);
        read_chk("R9 replay tape1 second", 16'h0001, 16'h2201, 1'b0);
        read_chk("R11 late append kept", 16'h0001, 16'h2202, 1'b0);
        read_chk("R3 tape1 drained", 16'h0001, '0, 1'b1);

        // R7: back-to-back requests keep valid high each cycle.
        @(negedge clk);
        rd_req = 1'b1; rd_sel = 16'h0000;
        @(negedge clk);
        check("R7 back-to-back first", rd_word, rd_flag, rd_valid, 16'h1102, 1'b0, 1'b1);
        rd_sel = 16'h0005;
        @(negedge clk);
        rd_req = 1'b0;
        check("R7 back-to-back second R4", rd_word, rd_flag, rd_valid, '0, 1'b1, 1'b1);
        read_chk("R4 bad selector left tape0", 16'h0000, 16'h1103, 1'b0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule